// File: doc/BRIEF.md
# Supply Supervisor Reset Stretcher

This block produces the system reset for a supply supervisor. A synchronous flag from an external comparator reports that the supply is under its trip level. While that flag is set, the block asserts reset at once. After the flag clears, it keeps reset asserted for a fixed number of clock cycles and then releases it. The default count gives 200 ms at a 200 MHz clock.

There are two reset pins of opposite polarity, and both are open-drain. One pin rises to assert and the other falls to assert. Each pin is modelled as a drive-enable output plus a sensed level input. The block only ever drives a pin to its asserted level. At release it stops driving, and the board pulls the pin back to idle.

Either pin also works as an input. A switch or another device that moves a pin from idle to asserted starts one full timeout. The pin input responds to that edge, not to the level, so a button held down does not lengthen reset. While the block is driving reset itself, edges on the pins are ignored, so its own drive cannot restart the timer. These are plain control pins with no data stream, so there is no handshake and no back-pressure.

Top module: `reset_stretcher`

## Requirements
- R1: While `rst_n` is low, both `rsth_oe_o` and `rstl_oe_o` are 1, meaning reset is driven.
- R2: In any cycle where `supply_low_i` is 1, both drive enables are 1 in that same cycle, with no register on the path.
- R3: Suppose `supply_low_i` is sampled at 1 on a rising edge and at 0 on the edges after it. Then both enables stay 1 for exactly `TIMEOUT_CYC` clock cycles after that edge and fall to 0 after the next edge.
- R4: With reset released, a 0-to-1 change on `rsth_pin_i` (1 = asserted) that first appears at rising edge k sets both enables to 1 after edge k+2. They stay at 1 for `TIMEOUT_CYC` cycles.
- R5: With reset released, a 1-to-0 change on `rstl_pin_i` (0 = asserted) that first appears at rising edge k has the same effect and the same timing as R4.
- R6: If a pin stays at its asserted level after a timeout it started, reset still releases after `TIMEOUT_CYC` cycles. The held level starts nothing new. Only a fresh idle-to-asserted change does.
- R7: Pin changes that the synchronised view reports while a drive enable is 1 start nothing. This covers the changes caused by the block's own drive, so a one-cycle supply dip gives exactly one timeout.
- R8: A new supply-low sample during a running timeout reloads the full count. Release then comes `TIMEOUT_CYC` cycles after the last supply-low sample.
- R9: The two drive enables are always equal. The block never drives a pin to its idle level.
- R10: After `rst_n` goes high with `supply_low_i` at 0, reset stays driven for `TIMEOUT_CYC` cycles and then releases.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset for the block's logic (power-on reset) |
| supply_low_i | input | 1 | Synchronous comparator flag; 1 means the supply is under its trip level |
| rsth_pin_i | input | 1 | Sensed level of the active-high reset pin |
| rstl_pin_i | input | 1 | Sensed level of the active-low reset pin |
| rsth_oe_o | output | 1 | 1 drives the active-high pin high |
| rstl_oe_o | output | 1 | 1 drives the active-low pin low |

## Verification
A supply-low sample shows on the enables in the same cycle. After the flag clears, the enables stay 1 for `TIMEOUT_CYC` more cycles. A pin change first sampled at edge k shows on the enables just after edge k+2, because of the two synchroniser flops and the edge register. The bench keeps a model of the countdown and of the three-deep sampled pin history, and advances it once per rising edge from the values it drove. It compares both enables at every falling edge, after the edge has settled. For R2 it also checks the enables one time step after raising the supply flag, before any clock edge.

// File: rtl/rst_str_pkg.sv
package rst_str_pkg;
  // Which level of a reset pin counts as asserted.
  typedef enum logic {
    POL_HIGH = 1'b0,
    POL_LOW  = 1'b1
  } pin_pol_e;

  // Timeout length in cycles for a clock rate and a time in milliseconds.
  function automatic int unsigned timeout_cycles(input int unsigned clk_hz,
                                                 input int unsigned ms);
    return (clk_hz / 1000) * ms;
  endfunction
endpackage

// File: rtl/rst_str_pin_sense.sv
module rst_str_pin_sense
  import rst_str_pkg::*;
#(
  parameter pin_pol_e POL = POL_HIGH
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic assert_edge_o
);
  // Raw level of the pin when no one drives it.
  localparam logic IDLE_LVL = (POL == POL_HIGH) ? 1'b0 : 1'b1;

  logic meta_q, sync_q, prev_q;
  logic act_now, act_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= IDLE_LVL;
      sync_q <= IDLE_LVL;
      prev_q <= IDLE_LVL;
    end else begin
      meta_q <= pin_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  // Convert to asserted sense: 1 = pin at its asserted level.
  generate
    if (POL == POL_HIGH) begin : g_high
      assign act_now  = sync_q;
      assign act_prev = prev_q;
    end else begin : g_low
      assign act_now  = ~sync_q;
      assign act_prev = ~prev_q;
    end
  endgenerate

  assign assert_edge_o = act_now & ~act_prev;
endmodule

// File: rtl/rst_str_timer.sv
module rst_str_timer #(
  parameter int unsigned TIMEOUT_CYC = 40_000_000,
  localparam int unsigned CNT_W      = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic busy_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(TIMEOUT_CYC);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= FULL;
    else if (load_i)          cnt_q <= FULL;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/reset_stretcher.sv
module reset_stretcher
  import rst_str_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 200_000_000,
  parameter int unsigned TIMEOUT_MS  = 200,
  parameter int unsigned TIMEOUT_CYC = timeout_cycles(CLK_HZ, TIMEOUT_MS)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_low_i,
  input  logic rsth_pin_i,
  input  logic rstl_pin_i,
  output logic rsth_oe_o,
  output logic rstl_oe_o
);
  localparam int NPIN = 2;

  logic [NPIN-1:0] pin_lvl;
  logic [NPIN-1:0] pin_edge;
  logic            busy_w;
  logic            drive_w;
  logic            pin_evt_w;
  logic            load_w;

  assign pin_lvl = {rstl_pin_i, rsth_pin_i};

  generate
    for (genvar i = 0; i < NPIN; i++) begin : g_pin
      rst_str_pin_sense #(
        .POL((i == 0) ? POL_HIGH : POL_LOW)
      ) u_sense (
        .clk          (clk),
        .rst_n        (rst_n),
        .pin_i        (pin_lvl[i]),
        .assert_edge_o(pin_edge[i])
      );
    end
  endgenerate

  // Reset is driven with no delay while the supply is low.
  assign drive_w   = supply_low_i | busy_w;
  // Edges seen while this block drives reset come from its own drive.
  assign pin_evt_w = (|pin_edge) & ~drive_w;
  assign load_w    = supply_low_i | pin_evt_w;

  rst_str_timer #(
    .TIMEOUT_CYC(TIMEOUT_CYC)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .load_i(load_w),
    .busy_o(busy_w)
  );

  assign rsth_oe_o = drive_w;
  assign rstl_oe_o = drive_w;
endmodule

// File: rtl/reset_stretcher_chk.sv
module reset_stretcher_chk #(
  parameter int unsigned TIMEOUT_CYC = 40_000_000,
  localparam int unsigned QW         = $clog2(TIMEOUT_CYC + 1) + 1
) (
  input logic clk,
  input logic rst_n,
  input logic supply_low_i,
  input logic pin_evt_i,
  input logic rsth_oe_o,
  input logic rstl_oe_o
);
  localparam logic [QW-1:0] LIMIT = QW'(TIMEOUT_CYC);

  // Cycles since the last supply-low sample or accepted pin event.
  logic [QW-1:0] quiet_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        quiet_q <= '0;
    else if (supply_low_i || pin_evt_i) quiet_q <= '0;
    else if (quiet_q < LIMIT)          quiet_q <= quiet_q + 1'b1;
  end

  AST_HOLD_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet_q < LIMIT) |-> (rsth_oe_o && rstl_oe_o)); // R3
  AST_RELEASE_DUE: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet_q >= LIMIT && !supply_low_i) |-> (!rsth_oe_o && !rstl_oe_o)); // R3
  AST_LOW_THEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    supply_low_i |=> (rsth_oe_o && rstl_oe_o)); // R8
  AST_START_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsth_oe_o) |-> (supply_low_i || $past(pin_evt_i))); // R4
  AST_PAIR_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rstl_oe_o) |-> $rose(rsth_oe_o)); // R9
endmodule

bind reset_stretcher reset_stretcher_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .supply_low_i(supply_low_i),
  .pin_evt_i   (pin_evt_w),
  .rsth_oe_o   (rsth_oe_o),
  .rstl_oe_o   (rstl_oe_o)
);

// File: tb/reset_stretcher_bench.sv
module reset_stretcher_bench;
  localparam int unsigned T = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_low = 1'b0;
  logic ext_h = 1'b0;
  logic ext_l = 1'b0;
  logic oe_h, oe_l;
  logic pin_h, pin_l;

  int checks = 0;
  int errors = 0;
  string tag = "R1";

  // Expected-state model.
  int unsigned rem = T;
  logic h1 = 0, h2 = 0, h3 = 0;
  logic l1 = 0, l2 = 0, l3 = 0;

  always #2.5 clk = ~clk;

  // Open-drain pins: asserted when the block or an outside source pulls.
  assign pin_h = oe_h | ext_h;
  assign pin_l = ~(oe_l | ext_l);

  reset_stretcher #(.TIMEOUT_CYC(T)) u_reset_stretcher (
    .clk         (clk),
    .rst_n       (rst_n),
    .supply_low_i(supply_low),
    .rsth_pin_i  (pin_h),
    .rstl_pin_i  (pin_l),
    .rsth_oe_o   (oe_h),
    .rstl_oe_o   (oe_l)
  );

  function automatic logic exp_drive(input logic sup, input int unsigned r);
    return sup || (r != 0);
  endfunction

  // Remaining count after one rising edge, per R3..R8.
  function automatic int unsigned next_rem(input logic sup, input logic edge_seen,
                                           input int unsigned r);
    if (sup || (edge_seen && !exp_drive(sup, r))) return T;
    if (r != 0) return r - 1;
    return 0;
  endfunction

  task automatic check(input string req, input logic act_h, input logic act_l,
                       input logic exp);
    checks++;
    if (act_h !== exp || act_l !== exp) begin
      errors++;
      $display("FAIL %s: oe_h=%b oe_l=%b expected %b at %0t", req, act_h, act_l, exp, $time);
    end
  endtask

  // Advance the model over one rising edge, then check at the falling edge.
  task automatic cycle();
    logic ev;
    #1;
    if (!rst_n) begin
      rem = T;
      {h1, h2, h3, l1, l2, l3} = '0;
    end else begin
      ev  = (h2 && !h3) || (l2 && !l3);
      rem = next_rem(supply_low, ev, rem);
      h3 = h2; h2 = h1; h1 = pin_h;
      l3 = l2; l2 = l1; l1 = ~pin_l;
    end
    @(posedge clk);
    @(negedge clk);
    check(tag, oe_h, oe_l, exp_drive(supply_low, rem));
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete, expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd20231));
    @(negedge clk);
    // R1: reset state
    tag = "R1";
    run(4);
    // R10: power-on timeout
    tag = "R10";
    rst_n = 1'b1;
    run(T + 6);
    // R2: immediate assertion, before any edge
    tag = "R2";
    supply_low = 1'b1;
    #0.5;
    check("R2", oe_h, oe_l, 1'b1);
    run(5);
    // R3: stretch after recovery
    tag = "R3";
    supply_low = 1'b0;
    run(T + 6);
    // R7: one-cycle dip, own drive ignored
    tag = "R7";
    supply_low = 1'b1;
    run(1);
    supply_low = 1'b0;
    run(T + 8);
    // R4: high pin pulse
    tag = "R4";
    ext_h = 1'b1;
    run(2);
    ext_h = 1'b0;
    run(T + 8);
    // R5: low pin pulse
    tag = "R5";
    ext_l = 1'b1;
    run(2);
    ext_l = 1'b0;
    run(T + 8);
    // R6: held level does not extend
    tag = "R6";
    ext_h = 1'b1;
    run(3 * T);
    ext_h = 1'b0;
    run(4);
    ext_l = 1'b1;
    run(3 * T);
    ext_l = 1'b0;
    run(T + 4);
    // R8: reload by supply mid-timeout, after an edge too
    tag = "R8";
    supply_low = 1'b1;
    run(1);
    supply_low = 1'b0;
    run(T / 2);
    supply_low = 1'b1;
    run(1);
    supply_low = 1'b0;
    run(T + 6);
    ext_h = 1'b1;
    run(1);
    ext_h = 1'b0;
    run(T / 2);
    supply_low = 1'b1;
    run(1);
    supply_low = 1'b0;
    run(T + 6);
    // R9: random mix, both outputs compared every cycle
    tag = "R9";
    for (int i = 0; i < 3000; i++) begin
      supply_low = ($urandom_range(99) < 2);
      if ($urandom_range(99) < 5) ext_h = ~ext_h;
      if ($urandom_range(99) < 5) ext_l = ~ext_l;
      cycle();
    end
    supply_low = 1'b0;
    ext_h = 1'b0;
    ext_l = 1'b0;
    run(T + 6);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule